// File: doc/BRIEF.md
# Cartridge Program Bank Mapper

This block sits between a processor bus with 16-bit addresses and 8-bit data and a set of external cartridge storage arrays. Every bus address is decoded into one of four storage regions: character memory, work RAM, a switchable program window and a fixed program window. For each access the block drives a one-hot region select and a flat physical offset into the matching array. Region select and offset are purely combinational from the address and the current bank register.

The program area is read-only from the bus. A write anywhere in it does not reach storage. Instead it loads a new bank number into the bank register, reduced modulo the bank count, and the new bank appears in the lower program window from the next cycle. The upper program window always shows the last bank. The number of 16 KiB program banks is the parameter `NUM_BANKS`.

Addresses in the gap between character memory and work RAM belong to no region. Any access there raises an error flag.

The bank register follows two named transitions. RESET forces bank 0. LOAD, taken on a clock edge with a program-area write, stores the reduced data. In every other cycle the register HOLDS its value. Decode follows the address field `addr[15:13]`.

Top module: `cart_bank_mapper`

## Requirements
- R1: Addresses 0x0000–0x1FFF select the character region (`rgn_sel` = 4'b0001, bit 0), and the offset equals the address.
- R2: Addresses 0x6000–0x7FFF select work RAM (`rgn_sel` = 4'b0010, bit 1), and the offset equals the address minus 0x6000.
- R3: Addresses 0x8000–0xBFFF select program storage (`rgn_sel` = 4'b0100, bit 2), and the offset equals (bank << 14) + (address − 0x8000).
- R4: Addresses 0xC000–0xFFFF select program storage (`rgn_sel` = 4'b0100), and the offset equals ((NUM_BANKS − 1) << 14) + (address − 0xC000), whatever the bank register holds.
- R5: A write to any address at or above 0x8000 loads the bank register with the write data modulo NUM_BANKS. A read in the following cycle sees the new bank.
- R6: After reset the bank register holds 0.
- R7: `store_we` equals `bus_we` for the character and work RAM regions, and is 0 for every other region.
- R8: Addresses 0x2000–0x5FFF give `rgn_sel` = 4'b1000 (none) and offset 0. `unmapped_err` is 1 there when `bus_re` or `bus_we` is high, and 0 in every other case.
- R9: `rgn_sel` always has exactly one bit set.
- R10: When NUM_BANKS is not a power of two, the modulo reduction is still exact for all 256 data values within the write cycle.
- R11: The bank register keeps its value on cycles without a program-area write, including writes to character memory or work RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| rgn_sel | output | 4 | One-hot region: bit0 character, bit1 work RAM, bit2 program, bit3 none |
| phys_off | output | OFF_W (14 + bank index width) | Flat offset into the selected storage |
| store_we | output | 1 | Write strobe forwarded to storage |
| unmapped_err | output | 1 | Access to an unmapped address |

## Verification
The bench sweeps addresses across the whole 64 KiB space with every region edge hit exactly. A decoder with an off-by-one boundary would misroute 0x1FFF/0x2000, 0x5FFF/0x6000 or 0xBFFF/0xC000. All 256 bank values are written into a power-of-two instance and into a six-bank instance. A faulty mask or subtract reduction would leave an out-of-range bank or a wrong offset. The bench also checks that the upper window stays on the last bank after switching, because a design that reused the bank register there would move it. It checks that writes to RAM regions leave the bank untouched and do not reach program storage. It checks that the error flag tracks the access strobes, so a flag raised on idle cycles would be caught.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    typedef enum logic [2:0] {
        RGN_CHR,
        RGN_WRAM,
        RGN_PRG_LO,
        RGN_PRG_HI,
        RGN_NONE
    } region_e;

    localparam int SEL_CHR  = 0;
    localparam int SEL_WRAM = 1;
    localparam int SEL_PRG  = 2;
    localparam int SEL_NONE = 3;

    localparam int PRG_WIN_BITS = 14;
    localparam int RAM_WIN_BITS = 13;

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_mapper_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region,
    output logic [3:0]  sel
);
    always_comb begin
        unique case (addr[15:13])
            3'b000:         region = RGN_CHR;
            3'b001, 3'b010: region = RGN_NONE;
            3'b011:         region = RGN_WRAM;
            3'b100, 3'b101: region = RGN_PRG_LO;
            default:        region = RGN_PRG_HI;
        endcase
    end

    always_comb begin
        sel = '0;
        unique case (region)
            RGN_CHR:                sel[SEL_CHR]  = 1'b1;
            RGN_WRAM:               sel[SEL_WRAM] = 1'b1;
            RGN_PRG_LO, RGN_PRG_HI: sel[SEL_PRG]  = 1'b1;
            default:                sel[SEL_NONE] = 1'b1;
        endcase
    end
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg #(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [7:0]        wdata,
    output logic [BANK_W-1:0] bank_q
);
    localparam bit IS_POW2 = (NUM_BANKS & (NUM_BANKS - 1)) == 0;

    logic [BANK_W-1:0] bank_d;

    generate
        if (NUM_BANKS == 1) begin : g_single
            assign bank_d = '0;
        end else if (IS_POW2) begin : g_mask
            assign bank_d = wdata[BANK_W-1:0];
        end else begin : g_reduce
            logic [7:0] rem;
            always_comb begin
                rem = wdata;
                for (int k = 7; k >= 0; k--) begin
                    if ({8'h00, rem} >= (16'(NUM_BANKS) << k)) begin
                        rem = rem - 8'((16'(NUM_BANKS) << k));
                    end
                end
            end
            assign bank_d = rem[BANK_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/cart_offset_gen.sv
module cart_offset_gen
    import cart_mapper_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int OFF_W  = PRG_WIN_BITS + BANK_W
) (
    input  logic [15:0]       addr,
    input  region_e           region,
    input  logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    always_comb begin
        unique case (region)
            RGN_CHR, RGN_WRAM: offset = OFF_W'(addr[RAM_WIN_BITS-1:0]);
            RGN_PRG_LO:        offset = {bank, addr[PRG_WIN_BITS-1:0]};
            RGN_PRG_HI:        offset = {LAST_BANK, addr[PRG_WIN_BITS-1:0]};
            default:           offset = '0;
        endcase
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_mapper_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int OFF_W  = PRG_WIN_BITS + BANK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    output logic [3:0]       rgn_sel,
    output logic [OFF_W-1:0] phys_off,
    output logic             store_we,
    output logic             unmapped_err
);
    region_e           region;
    logic [BANK_W-1:0] bank_q;
    logic              bank_load;

    cart_addr_decode u_dec (
        .addr   (bus_addr),
        .region (region),
        .sel    (rgn_sel)
    );

    assign bank_load = bus_we && (region == RGN_PRG_LO || region == RGN_PRG_HI);

    cart_bank_reg #(.NUM_BANKS(NUM_BANKS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bank_load),
        .wdata  (bus_wdata),
        .bank_q (bank_q)
    );

    cart_offset_gen #(.NUM_BANKS(NUM_BANKS)) u_off (
        .addr   (bus_addr),
        .region (region),
        .bank   (bank_q),
        .offset (phys_off)
    );

    assign store_we     = bus_we && (region == RGN_CHR || region == RGN_WRAM);
    assign unmapped_err = (bus_we || bus_re) && (region == RGN_NONE);
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int OFF_W  = 14 + BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [3:0]        rgn_sel,
    input logic [OFF_W-1:0]  phys_off,
    input logic              store_we,
    input logic              unmapped_err,
    input logic [BANK_W-1:0] bank_q
);
    assert_onehot_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgn_sel) == 1);

    assert_bank_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[15]) |=> (32'(bank_q) == 32'($past(bus_wdata)) % NUM_BANKS));

    assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr[15]) |=> $stable(bank_q));

    assert_reset_bank_R6: assert property (@(posedge clk)
        !rst_n |=> bank_q == '0);

    assert_store_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> (bus_we && (rgn_sel[0] || rgn_sel[1])));

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_err |-> (rgn_sel[3] && (bus_we || bus_re)));

    assert_fixed_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:14] == 2'b11) |-> (32'(phys_off[OFF_W-1:14]) == NUM_BANKS - 1));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .rgn_sel      (rgn_sel),
    .phys_off     (phys_off),
    .store_we     (store_we),
    .unmapped_err (unmapped_err),
    .bank_q       (bank_q)
);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
    localparam int OFF_W = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;

    logic [3:0]       sel8, sel6;
    logic [OFF_W-1:0] off8, off6;
    logic             swe8, swe6, err8, err6;

    int checks = 0;
    int errors = 0;
    int bank8 = 0;
    int bank6 = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cart_bank_mapper #(.NUM_BANKS(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .rgn_sel(sel8), .phys_off(off8),
        .store_we(swe8), .unmapped_err(err8));

    cart_bank_mapper #(.NUM_BANKS(6)) u_dut6 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .rgn_sel(sel6), .phys_off(off6),
        .store_we(swe6), .unmapped_err(err6));

    function automatic int exp_sel(int a);
        if (a < 'h2000) return 1;
        if (a < 'h6000) return 8;
        if (a < 'h8000) return 2;
        return 4;
    endfunction

    function automatic int exp_off(int a, int bank, int n);
        if (a < 'h2000) return a;
        if (a < 'h6000) return 0;
        if (a < 'h8000) return a - 'h6000;
        if (a < 'hC000) return bank * 16384 + (a - 'h8000);
        return (n - 1) * 16384 + (a - 'hC000);
    endfunction

    function automatic string tag_of(int a);
        if (a < 'h2000) return "R1";
        if (a < 'h6000) return "R8";
        if (a < 'h8000) return "R2";
        if (a < 'hC000) return "R3";
        return "R4";
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic check_addr(int a, bit we, bit re);
        int es;
        int ew;
        int ee;
        bus_addr = 16'(a);
        bus_we = we;
        bus_re = re;
        #1;
        es = exp_sel(a);
        ew = (we && (es == 1 || es == 2)) ? 1 : 0;
        ee = ((we || re) && es == 8) ? 1 : 0;
        chk(int'(sel8) == es, tag_of(a), int'(sel8), es);
        chk(int'(sel6) == es, "R9", int'(sel6), es);
        chk(int'(off8) == exp_off(a, bank8, 8), tag_of(a), int'(off8), exp_off(a, bank8, 8));
        chk(int'(off6) == exp_off(a, bank6, 6), tag_of(a), int'(off6), exp_off(a, bank6, 6));
        chk(int'(swe8) == ew && int'(swe6) == ew, "R7", int'(swe8), ew);
        chk(int'(err8) == ee && int'(err6) == ee, "R8", int'(err8), ee);
    endtask

    task automatic bus_write(int a, int d);
        @(negedge clk);
        bus_addr = 16'(a);
        bus_wdata = 8'(d);
        bus_we = 1'b1;
        bus_re = 1'b0;
        #1;
        chk(swe8 == 1'b0 && swe6 == 1'b0 || a < 'h8000, "R7", int'(swe8), 0);
        @(negedge clk);
        bus_we = 1'b0;
        if (a >= 'h8000) begin
            bank8 = d % 8;
            bank6 = d % 6;
        end
    endtask

    task automatic sweep(bit we, bit re);
        int edges[9] = '{'h1FFF, 'h2000, 'h5FFF, 'h6000, 'h7FFF, 'h8000, 'hBFFF, 'hC000, 'hFFFF};
        for (int a = 0; a < 65536; a += 37) begin
            if (!(we && a >= 'h8000)) check_addr(a, we, re);
        end
        foreach (edges[i]) begin
            if (!(we && edges[i] >= 'h8000)) check_addr(edges[i], we, re);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset state seen through the lower window
        check_addr('h8000, 1'b0, 1'b1);
        chk(off8 == '0 && off6 == '0, "R6", int'(off8), 0);
        check_addr('h2000, 1'b0, 1'b0);
        chk(err8 == 1'b0, "R8", int'(err8), 0);

        sweep(1'b0, 1'b1);
        sweep(1'b0, 1'b0);

        // R5 R10: every data value on both instances
        for (int d = 0; d < 256; d++) begin
            bus_write('h8000 + ((d * 97) & 'h7FFF), d);
            check_addr('h8123, 1'b0, 1'b1);
            chk(int'(off8[16:14]) == d % 8, "R5", int'(off8[16:14]), d % 8);
            chk(int'(off6[16:14]) == d % 6, "R10", int'(off6[16:14]), d % 6);
            check_addr('hC000 + (d * 61 % 'h4000), 1'b0, 1'b1);
        end

        // R11: RAM writes leave the bank alone
        bus_write('h8000, 'hFD);
        bus_write('h6000, 'h02);
        bus_write('h0010, 'h01);
        check_addr('h9000, 1'b0, 1'b1);
        chk(int'(off8[16:14]) == 5 && int'(off6[16:14]) == 1, "R11", int'(off8[16:14]), 5);

        sweep(1'b1, 1'b0);
        sweep(1'b0, 1'b1);

        bus_we = 1'b0;
        bus_re = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule